// File: doc/BRIEF.md
# Bit-Band Alias Access Translator

This block sits on the path from one bus initiator to a word-wide memory or peripheral port. It watches every request for addresses inside two alias windows, where each 32-bit alias word stands for one bit of a byte in an underlying region. A request outside the windows, or one from a source not marked as the bit-band initiator, goes through untouched in the same cycle.

An alias read becomes one downstream read of the word holding the target byte, and the initiator gets only the chosen bit, placed in bit 0. An alias write becomes a locked pair of downstream transfers, a read followed at once by a write of the same word, so that only the chosen bit changes. The initiator is held off until the write half has been taken.

The alias word at offset `k` in a window selects byte `k / 32` of the region and bit `(k / 4) mod 8` of that byte. Bytes are little-endian inside a downstream word, so byte lane `b` covers word bits `8b+7 .. 8b`.

Top module: `bb_alias_xlate`

## Requirements
- R1: A request that is not translated is passed straight through in the same cycle: dn_valid, dn_addr, dn_write and dn_wdata equal the upstream values, up_ready equals dn_ready, and up_rdata equals dn_rdata.
- R2: With up_bb_en = 1, an address in 0x2200_0000 .. 0x227F_FFFF is translated to target byte 0x2000_0000 + (A - 0x2200_0000) / 32 and bit ((A - 0x2200_0000) / 4) mod 8; dn_addr is that byte address with bits 1:0 cleared (0x2200_6008 selects bit 2 of byte 0x2000_0300).
- R3: With up_bb_en = 1, an address in 0x4200_0000 .. 0x42FF_FFFF is translated the same way onto the region starting at 0x4000_0000.
- R4: An alias read issues one downstream read (dn_write = 0) and returns in up_rdata the word bit 8*(byte address mod 4) + bit number of dn_rdata in bit 0, with bits 31:1 zero; up_ready follows dn_ready.
- R5: An alias write issues a downstream read and then a downstream write to the same word; the written word equals the word read with only the target bit replaced by up_wdata[0]; bits 31:1 of up_wdata have no effect.
- R6: The write half is presented in the cycle right after the read half is accepted and is held until dn_ready; up_ready stays 0 during the read half and is 1 exactly in the cycle the write half is accepted.
- R7: With up_bb_en = 0, an address inside either window is passed through as in R1.
- R8: Addresses just outside the windows (0x21FF_FFFC, 0x2280_0000, 0x41FF_FFFC, 0x4300_0000) are passed through as in R1.
- R9: After a synchronous active-low reset with no request, dn_valid is 0.
- R10: Bits 1:0 of an alias address are ignored: 0x2200_600B selects the same bit as 0x2200_6008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Upstream request valid, held until up_ready |
| up_ready | output | 1 | Upstream request taken; read data valid in this cycle |
| up_addr | input | 32 | Upstream byte address |
| up_write | input | 1 | 1 = write, 0 = read |
| up_wdata | input | 32 | Upstream write data |
| up_bb_en | input | 1 | Request comes from the bit-band initiator |
| up_rdata | output | 32 | Upstream read data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request taken; dn_rdata valid in this cycle |
| dn_addr | output | 32 | Downstream byte address |
| dn_write | output | 1 | Downstream write flag |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The hardest case to reach is an alias write whose read half or write half is stalled by the downstream port for several cycles, because the held write must keep its address and merged word while the upstream side sees no ready. The bench reaches it by toggling dn_ready from a pseudo-random source on every cycle while the random phase mixes alias reads and writes on a small set of bytes, so later alias reads and plain reads land on words changed by earlier stalled writes. Each cycle the bench compares the downstream request and the upstream ready against a model of the expected phase.

// File: rtl/bb_alias_pkg.sv
// Package: shared widths and types for the bit-band alias translator.
// Assumes a 32-bit byte address and a 32-bit data word; one alias word
// stands for one bit, so a byte spans 8 * 4 = 32 alias bytes.
package bb_alias_pkg;
    localparam int unsigned BB_ADDR_W     = 32;
    localparam int unsigned BB_DATA_W     = 32;
    localparam int unsigned BB_BIT_W      = $clog2(BB_DATA_W);
    localparam int unsigned BB_LANE_W     = $clog2(BB_DATA_W / 8);
    localparam int unsigned BB_BITNUM_W   = 3;
    localparam int unsigned BB_ALIAS_SHFT = BB_BITNUM_W + 2;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_WRITE = 1'b1
    } bb_seq_state_e;

    typedef struct packed {
        logic                 hit;
        logic [BB_ADDR_W-1:0] word_addr;
        logic [BB_BIT_W-1:0]  bit_idx;
    } bb_target_t;
endpackage

// File: rtl/bb_alias_window.sv
// Module: decodes one alias window. Flags a hit and computes the
// word-aligned target address and the bit index inside that word.
// Assumes ALIAS_BASE is aligned to 2**SPAN_LOG2.
module bb_alias_window
    import bb_alias_pkg::*;
#(
    parameter logic [BB_ADDR_W-1:0] ALIAS_BASE  = 32'h2200_0000,
    parameter int unsigned          SPAN_LOG2   = 23,
    parameter logic [BB_ADDR_W-1:0] REGION_BASE = 32'h2000_0000
) (
    input  logic [BB_ADDR_W-1:0] addr_i,
    output bb_target_t           tgt_o
);
    localparam int unsigned BYTE_OFF_W = SPAN_LOG2 - BB_ALIAS_SHFT;

    logic [BYTE_OFF_W-1:0]  byte_off;
    logic [BB_BITNUM_W-1:0] bit_num;
    logic [BB_ADDR_W-1:0]   byte_addr;
    logic                   unused_addr_lsb;

    assign unused_addr_lsb = ^addr_i[1:0];

    // Split the alias offset and form the target byte address.
    always_comb begin
        byte_off  = addr_i[SPAN_LOG2-1:BB_ALIAS_SHFT];
        bit_num   = addr_i[BB_ALIAS_SHFT-1:2];
        byte_addr = REGION_BASE + {{(BB_ADDR_W-BYTE_OFF_W){1'b0}}, byte_off};
        tgt_o.hit       = (addr_i[BB_ADDR_W-1:SPAN_LOG2] == ALIAS_BASE[BB_ADDR_W-1:SPAN_LOG2]);
        tgt_o.word_addr = {byte_addr[BB_ADDR_W-1:BB_LANE_W], {BB_LANE_W{1'b0}}};
        tgt_o.bit_idx   = {byte_addr[BB_LANE_W-1:0], bit_num};
    end
endmodule

// File: rtl/bb_rmw_seq.sv
// Module: sequences the write half of an alias read-modify-write.
// The read half is issued by the top while this block is idle; when it
// is accepted the word is captured and the merged word is presented
// until the downstream port takes it. Assumes start_i is only high
// while an alias write is presented.
module bb_rmw_seq
    import bb_alias_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 dn_ready_i,
    input  logic [BB_DATA_W-1:0] rd_word_i,
    input  logic [BB_ADDR_W-1:0] tgt_addr_i,
    input  logic [BB_BIT_W-1:0]  tgt_bit_i,
    input  logic                 new_bit_i,
    output logic                 wr_phase_o,
    output logic [BB_ADDR_W-1:0] wr_addr_o,
    output logic [BB_DATA_W-1:0] wr_word_o
);
    bb_seq_state_e        state;
    logic [BB_DATA_W-1:0] hold_word;
    logic [BB_BIT_W-1:0]  lat_bit;
    logic                 lat_new;

    // Phase register: idle until the read half is taken, then write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            case (state)
                SEQ_IDLE:  if (start_i && dn_ready_i) state <= SEQ_WRITE;
                SEQ_WRITE: if (dn_ready_i) state <= SEQ_IDLE;
                default:   state <= SEQ_IDLE;
            endcase
        end
    end

    // Capture the word read and the target of the pending write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word <= '0;
            wr_addr_o <= '0;
            lat_bit   <= '0;
            lat_new   <= 1'b0;
        end else if (state == SEQ_IDLE && start_i && dn_ready_i) begin
            hold_word <= rd_word_i;
            wr_addr_o <= tgt_addr_i;
            lat_bit   <= tgt_bit_i;
            lat_new   <= new_bit_i;
        end
    end

    assign wr_phase_o = (state == SEQ_WRITE);

    // Merge the new bit into the captured word, one lane per bit.
    for (genvar i = 0; i < BB_DATA_W; i++) begin : g_merge
        assign wr_word_o[i] = (lat_bit == BB_BIT_W'(i)) ? lat_new : hold_word[i];
    end

    // R6
    wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_phase_o && start_i && dn_ready_i) |=> wr_phase_o);

    // R6
    wr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_phase_o && !dn_ready_i) |=> (wr_phase_o && $stable(wr_addr_o) && $stable(wr_word_o)));

    // R6
    wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_phase_o && dn_ready_i) |=> !wr_phase_o);

    // R5
    one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase_o |-> ($countones(wr_word_o ^ hold_word) <= 1));
endmodule

// File: rtl/bb_alias_xlate.sv
// Module: top of the bit-band alias translator. Decodes the alias
// windows, steers pass-through, alias read and alias write traffic onto
// the downstream port and returns read data. Assumes the upstream
// request is held stable while up_valid is high and up_ready is low,
// and that downstream read data is valid in the accept cycle.
module bb_alias_xlate
    import bb_alias_pkg::*;
#(
    parameter int unsigned                        NUM_WIN         = 2,
    parameter logic [NUM_WIN-1:0][BB_ADDR_W-1:0]  WIN_ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN-1:0][7:0]            WIN_SPAN_LOG2   = {8'd24, 8'd23},
    parameter logic [NUM_WIN-1:0][BB_ADDR_W-1:0]  WIN_REGION_BASE = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 up_valid,
    output logic                 up_ready,
    input  logic [BB_ADDR_W-1:0] up_addr,
    input  logic                 up_write,
    input  logic [BB_DATA_W-1:0] up_wdata,
    input  logic                 up_bb_en,
    output logic [BB_DATA_W-1:0] up_rdata,
    output logic                 dn_valid,
    input  logic                 dn_ready,
    output logic [BB_ADDR_W-1:0] dn_addr,
    output logic                 dn_write,
    output logic [BB_DATA_W-1:0] dn_wdata,
    input  logic [BB_DATA_W-1:0] dn_rdata
);
    bb_target_t           win_tgt [NUM_WIN];
    logic                 xl_hit;
    logic [BB_ADDR_W-1:0] xl_addr;
    logic [BB_BIT_W-1:0]  xl_bit;
    logic                 is_alias;
    logic                 rmw_start;
    logic                 wr_phase;
    logic [BB_ADDR_W-1:0] wr_addr;
    logic [BB_DATA_W-1:0] wr_word;

    // One decoder per alias window.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        bb_alias_window #(
            .ALIAS_BASE  (WIN_ALIAS_BASE[w]),
            .SPAN_LOG2   (int'(WIN_SPAN_LOG2[w])),
            .REGION_BASE (WIN_REGION_BASE[w])
        ) u_win (
            .addr_i (up_addr),
            .tgt_o  (win_tgt[w])
        );
    end

    // Pick the lowest-numbered window that hits.
    always_comb begin
        xl_hit  = 1'b0;
        xl_addr = '0;
        xl_bit  = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (win_tgt[w].hit) begin
                xl_hit  = 1'b1;
                xl_addr = win_tgt[w].word_addr;
                xl_bit  = win_tgt[w].bit_idx;
            end
        end
    end

    assign is_alias  = up_bb_en && xl_hit;
    assign rmw_start = up_valid && is_alias && up_write && !wr_phase;

    bb_rmw_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (rmw_start),
        .dn_ready_i (dn_ready),
        .rd_word_i  (dn_rdata),
        .tgt_addr_i (xl_addr),
        .tgt_bit_i  (xl_bit),
        .new_bit_i  (up_wdata[0]),
        .wr_phase_o (wr_phase),
        .wr_addr_o  (wr_addr),
        .wr_word_o  (wr_word)
    );

    // Steer the downstream request and the upstream response.
    always_comb begin
        if (wr_phase) begin
            dn_valid = 1'b1;
            dn_addr  = wr_addr;
            dn_write = 1'b1;
            dn_wdata = wr_word;
            up_ready = dn_ready;
            up_rdata = '0;
        end else if (is_alias) begin
            dn_valid = up_valid;
            dn_addr  = xl_addr;
            dn_write = 1'b0;
            dn_wdata = '0;
            up_ready = up_write ? 1'b0 : dn_ready;
            up_rdata = {{(BB_DATA_W-1){1'b0}}, dn_rdata[xl_bit]};
        end else begin
            dn_valid = up_valid;
            dn_addr  = up_addr;
            dn_write = up_write;
            dn_wdata = up_wdata;
            up_ready = dn_ready;
            up_rdata = dn_rdata;
        end
    end

    // R1
    pass_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !is_alias && !wr_phase) |-> (dn_addr == up_addr && dn_write == up_write));

    // R4
    rd_bit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && is_alias && !up_write && !wr_phase) |-> (up_rdata[BB_DATA_W-1:1] == '0));

    // R6
    no_early_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rmw_start) |-> !up_ready);

    // R5
    rmw_same_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rmw_start && dn_ready) |=> (dn_addr == $past(dn_addr) && dn_write));
endmodule

// File: tb/bb_alias_xlate_bench.sv
`timescale 1ns/1ps
module bb_alias_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        up_valid, up_ready, up_write, up_bb_en;
    logic [31:0] up_addr, up_wdata, up_rdata;
    logic        dn_valid, dn_ready, dn_write;
    logic [31:0] dn_addr, dn_wdata, dn_rdata;

    int          n_cmp = 0;
    int          n_bad = 0;
    int          ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] mem  [int unsigned];
    logic [31:0] gold [int unsigned];
    logic [31:0] last_rdata;
    logic [31:0] first_dn_addr;

    always #4 clk = ~clk;

    bb_alias_xlate u_bb_alias_xlate (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
        .up_write(up_write), .up_wdata(up_wdata), .up_bb_en(up_bb_en),
        .up_rdata(up_rdata),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
        .dn_write(dn_write), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    function automatic logic [31:0] seed_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hC3A5_5A3C;
    endfunction

    function logic [31:0] mem_rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return seed_word(a);
    endfunction

    function logic [31:0] gold_rd(input logic [31:0] a);
        if (gold.exists(a)) return gold[a];
        return seed_word(a);
    endfunction

    // Expected translation, from the window definitions.
    function automatic bit xlate(input logic [31:0] a, output logic [31:0] wa, output int bi);
        longint unsigned off;
        logic [31:0]     byte_a;
        wa = '0; bi = 0;
        if (a >= 32'h2200_0000 && a <= 32'h227F_FFFF) begin
            off = longint'(a) - 64'h2200_0000;
            byte_a = 32'h2000_0000 + 32'(off / 32);
        end else if (a >= 32'h4200_0000 && a <= 32'h42FF_FFFF) begin
            off = longint'(a) - 64'h4200_0000;
            byte_a = 32'h4000_0000 + 32'(off / 32);
        end else begin
            return 1'b0;
        end
        wa = byte_a & 32'hFFFF_FFFC;
        bi = int'(byte_a % 4) * 8 + int'((off % 32) / 4);
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Downstream stall source and combinational read data model.
    always @(negedge clk) begin
        dn_ready = (ready_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[5]);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        #1 dn_rdata = mem_rd(dn_addr);
    end

    // Downstream memory write.
    always @(posedge clk) begin
        if (rst_n && dn_valid && dn_ready && dn_write) mem[dn_addr] = dn_wdata;
    end

    // One upstream transfer, compared against the phase model every cycle.
    task automatic xfer(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                        input bit bb, input string req);
        logic [31:0] xa, gw, exp_w;
        int          bi, cyc;
        bit          al, ph, fin;
        al = xlate(a, xa, bi);
        al = al && bb;
        exp_w = '0;
        @(negedge clk);
        up_valid = 1'b1; up_addr = a; up_write = wr; up_wdata = wd; up_bb_en = bb;
        ph = 1'b0; fin = 1'b0; cyc = 0;
        #2 first_dn_addr = dn_addr;
        #0;
        while (!fin) begin
            if (cyc > 0) #2;
            if (!al) begin
                chk(dn_valid === 1'b1 && dn_addr === a && dn_write === wr, req, "pass request", dn_addr, a);
                if (wr) chk(dn_wdata === wd, req, "pass wdata", dn_wdata, wd);
                chk(up_ready === dn_ready, req, "pass ready", {31'b0, up_ready}, {31'b0, dn_ready});
                if (dn_ready && !wr) begin
                    last_rdata = up_rdata;
                    chk(up_rdata === gold_rd(a), req, "pass rdata", up_rdata, gold_rd(a));
                end
                fin = dn_ready;
            end else if (!wr) begin
                chk(dn_valid === 1'b1 && dn_write === 1'b0 && dn_addr === xa, req, "R4 alias read request", dn_addr, xa);
                chk(up_ready === dn_ready, req, "R4 alias read ready", {31'b0, up_ready}, {31'b0, dn_ready});
                gw = gold_rd(xa);
                if (dn_ready) begin
                    last_rdata = up_rdata;
                    chk(up_rdata === {31'b0, gw[bi]}, req, "R4 alias read data", up_rdata, {31'b0, gw[bi]});
                end
                fin = dn_ready;
            end else if (!ph) begin
                chk(dn_valid === 1'b1 && dn_write === 1'b0 && dn_addr === xa, req, "R5 read half", dn_addr, xa);
                chk(up_ready === 1'b0, req, "R6 ready low in read half", {31'b0, up_ready}, 32'h0);
                if (dn_ready) ph = 1'b1;
            end else begin
                gw = gold_rd(xa);
                exp_w = gw;
                exp_w[bi] = wd[0];
                chk(dn_valid === 1'b1 && dn_write === 1'b1 && dn_addr === xa, req, "R6 write half request", dn_addr, xa);
                chk(dn_wdata === exp_w, req, "R5 merged word", dn_wdata, exp_w);
                chk(up_ready === dn_ready, req, "R6 ready on write accept", {31'b0, up_ready}, {31'b0, dn_ready});
                fin = dn_ready;
            end
            @(posedge clk);
            cyc++;
            if (cyc > 200) begin
                chk(1'b0, req, "R6 transfer timeout", cyc, 200);
                fin = 1'b1;
            end
            if (!fin) @(negedge clk);
        end
        if (!al && wr) gold[a] = wd;
        else if (al && wr) gold[xa] = exp_w;
        #1;
        if (al && wr) chk(mem_rd(xa) === exp_w, req, "R5 stored word", mem_rd(xa), exp_w);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R6 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; up_valid = 1'b0; up_addr = '0; up_write = 1'b0;
        up_wdata = '0; up_bb_en = 1'b0; dn_rdata = '0; dn_ready = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk); #2;
        chk(dn_valid === 1'b0, "R9", "dn_valid in reset", {31'b0, dn_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk(dn_valid === 1'b0, "R9", "dn_valid after reset", {31'b0, dn_valid}, 32'h0);

        ready_mode = 0;
        xfer(32'h2000_0300, 1'b1, 32'h0000_0004, 1'b1, "R1");
        xfer(32'h2200_6008, 1'b0, 32'h0, 1'b1, "R2");
        chk(first_dn_addr === 32'h2000_0300, "R2", "example word", first_dn_addr, 32'h2000_0300);
        chk(last_rdata === 32'h1, "R2", "example bit", last_rdata, 32'h1);
        xfer(32'h2200_600B, 1'b0, 32'h0, 1'b1, "R10");
        chk(last_rdata === 32'h1, "R10", "low bits ignored", last_rdata, 32'h1);
        xfer(32'h2200_6008, 1'b1, 32'hFFFF_FFFE, 1'b1, "R5");
        xfer(32'h2200_601C, 1'b1, 32'h0000_0001, 1'b1, "R5");
        xfer(32'h2000_0300, 1'b0, 32'h0, 1'b1, "R5");
        chk(last_rdata === 32'h0000_0080, "R5", "only target bits changed", last_rdata, 32'h0000_0080);
        xfer(32'h42FF_FFFC, 1'b1, 32'h0000_0001, 1'b1, "R3");
        chk(first_dn_addr === 32'h4007_FFFC, "R3", "top alias word", first_dn_addr, 32'h4007_FFFC);
        xfer(32'h4007_FFFC, 1'b0, 32'h0, 1'b1, "R3");
        chk(last_rdata[31] === 1'b1, "R3", "bit 31 set", {31'b0, last_rdata[31]}, 32'h1);
        xfer(32'h4200_0000, 1'b0, 32'h0, 1'b1, "R3");
        chk(first_dn_addr === 32'h4000_0000, "R3", "base alias word", first_dn_addr, 32'h4000_0000);
        xfer(32'h2200_6008, 1'b1, 32'hDEAD_BEEF, 1'b0, "R7");
        xfer(32'h2000_0300, 1'b0, 32'h0, 1'b1, "R7");
        chk(last_rdata === 32'h0000_0080, "R7", "target untouched", last_rdata, 32'h0000_0080);
        xfer(32'h21FF_FFFC, 1'b0, 32'h0, 1'b1, "R8");
        xfer(32'h2280_0000, 1'b1, 32'h1234_5678, 1'b1, "R8");
        xfer(32'h41FF_FFFC, 1'b1, 32'h0BAD_F00D, 1'b1, "R8");
        xfer(32'h4300_0000, 1'b0, 32'h0, 1'b1, "R8");

        ready_mode = 1;
        for (int n = 0; n < 400; n++) begin
            int          k;
            logic [31:0] a;
            bit          wr;
            k  = $urandom_range(0, 5);
            wr = 1'($urandom_range(0, 1));
            case (k)
                0:       a = 32'h2000_0000 + 4 * $urandom_range(0, 15);
                1, 2:    a = 32'h2200_0000 + 32 * $urandom_range(0, 63) + 4 * $urandom_range(0, 7) + $urandom_range(0, 3);
                3:       a = 32'h4200_0000 + 32 * $urandom_range(0, 63) + 4 * $urandom_range(0, 7);
                4:       a = 32'h4000_0000 + 4 * $urandom_range(0, 15);
                default: a = 32'h2200_0000 + 4 * $urandom_range(0, 15);
            endcase
            if (k == 5)      xfer(a, wr, $urandom(), 1'b0, "R7");
            else if (k == 0 || k == 4) xfer(a, wr, $urandom(), 1'b1, "R1");
            else if (wr)     xfer(a, 1'b1, $urandom(), 1'b1, "R5");
            else             xfer(a, 1'b0, 32'h0, 1'b1, "R4");
        end

        @(negedge clk);
        up_valid = 1'b0;
        repeat (2) @(posedge clk);
        summary();
        $finish;
    end
endmodule